// File: doc/BRIEF.md
# Battery Pack Protection Qualifier

This block watches the digitised readings of a battery pack and decides when to take the pack off line. Each cycle it receives the highest and lowest cell voltage, the signed voltage across the current-sense shunt and the pack temperature. It compares each reading against a threshold that the host can program. A fault class is declared only when its condition has held for that class's own persistence delay, and the delays range from tens of microseconds to half a second. Each fault class stops only the power FET for its own direction of current flow. When a reading moves back past its threshold by a fixed hysteresis margin, the fault clears.

A ninth class is a safety overvoltage check at a higher cell limit. Once it trips, it sets a permanent-fail latch that only a reset clears. A policy input decides how far the response to a permanent fail goes: raise a flag only, also hold both FETs off, or also fire the fuse output. A second mode input decides who controls the FETs: the protections alone, the protections together with the host, or the host alone. A small write/read port gives the host access to the thresholds, to a sticky fault log and to the live fault vector. The ADC conversions and the analog gate drive sit outside this block.

Top module: `prot_guard`

## Requirements
- R1: After reset no FET-off request, fuse or permanent-fail flag is active. Threshold register 0 reads 4300 (mV), and register 8 reads 4500.
- R2: Overvoltage (class bit 0) trips when cell_hi >= threshold 0 (4300 mV by default) has held for DLY_OV ticks. It asserts chg_off only, after exactly DLY_OV qualifying ticks and not one tick earlier.
- R3: If a condition drops out for a single tick before its delay expires, the persistence count restarts, and a full delay is needed again.
- R4: A recoverable fault clears on the first tick where the reading is past its threshold by more than the hysteresis (100 mV for cell classes). A reading inside the hysteresis band keeps the fault.
- R5: Undervoltage (bit 1) trips when cell_lo <= 2500 mV has held for DLY_UV ticks, and asserts dsg_off only.
- R6: Short circuit in discharge (bit 2) trips when shunt <= -8000 (LSB 10 uV, negative means discharge) has held for DLY_SCD ticks, and asserts dsg_off.
- R7: Overcurrent in charge (bit 3) trips when shunt >= 800 has held for DLY_OCC ticks, and asserts chg_off.
- R8: Temperature is in units of 0.1 C. Charge overtemperature (bit 4, >= 450) and charge undertemperature (bit 6, <= 0) assert chg_off. Discharge overtemperature (bit 5, >= 600) and discharge undertemperature (bit 7, <= -200) assert dsg_off. Each of these classes qualifies over DLY_TEMP ticks.
- R9: Address 9 is a sticky log with one bit per class (bit n = class n, bit 8 = safety overvoltage). Writing 1s to address 9 clears those bits. Address 10 reads the live fault vector in the same bit layout.
- R10: A write to address 0..8 replaces that class's threshold, and later qualification uses the new value.
- R11: fet_mode 0 lets the protections alone drive the FET-off outputs and ignores the host bits. Mode 1 ORs the host bits into the outputs. Modes 2 and 3 pass only the host bits, and faults are still logged.
- R12: Safety overvoltage (bit 8, cell_hi >= 4500 for DLY_SOV ticks) sets pf_flag. With pf_mode 0 only the flag is raised. Mode 1 also forces both FETs off. Modes 2 and 3 also assert fuse_fire and force both FETs off in every fet_mode.
- R13: The permanent-fail latch stays set after the reading recovers and clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_hi | input | 16 | Highest cell voltage, mV, unsigned |
| cell_lo | input | 16 | Lowest cell voltage, mV, unsigned |
| shunt | input | 16 | Signed shunt voltage, LSB 10 uV, positive = charging |
| temp | input | 16 | Signed temperature, LSB 0.1 C |
| pf_mode | input | 2 | Permanent-fail policy: 0 flag, 1 FETs off, 2/3 fuse |
| fet_mode | input | 2 | FET control: 0 protections, 1 shared, 2/3 host |
| host_chg_off | input | 1 | Host request to open the charge FET |
| host_dsg_off | input | 1 | Host request to open the discharge FET |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| chg_off | output | 1 | Request to open the charge FET |
| dsg_off | output | 1 | Request to open the discharge FET |
| fuse_fire | output | 1 | Fuse drive request |
| pf_flag | output | 1 | Permanent-fail latch |

## Verification
The assertions assume that the readings are already valid samples that change only at clock edges. They also assume the host does not write a threshold in the same tick in which it expects a class to qualify. The bench drives every input one nanosecond after a rising edge and keeps each stimulus steady for whole tick counts. It programs thresholds only while all readings sit at nominal values, so no count is running when a threshold changes. The mode inputs are combinational paths to the outputs, so the bench changes them only while the fault state is stable.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int NCLS = 9;

  typedef enum int unsigned {
    C_OV = 0, C_UV = 1, C_SCD = 2, C_OCC = 3,
    C_OTC = 4, C_OTD = 5, C_UTC = 6, C_UTD = 7, C_SOV = 8
  } cls_e;

  // classes that stop the charge FET / discharge FET
  localparam logic [NCLS-1:0] CHG_SIDE    = 9'b0_0101_1001;
  localparam logic [NCLS-1:0] DSG_SIDE    = 9'b0_1010_0110;
  // compare direction: 1 = trip at or above threshold
  localparam logic [NCLS-1:0] ABOVE_MASK  = 9'b1_0011_1101;
  // classes that never recover
  localparam logic [NCLS-1:0] STICKY_MASK = 9'b1_0000_0000;

  localparam int unsigned ADDR_STAT = 9;
  localparam int unsigned ADDR_LIVE = 10;

  localparam logic [1:0] FM_AUTO   = 2'd0;
  localparam logic [1:0] FM_SHARED = 2'd1;
  localparam logic [1:0] PF_FLAG   = 2'd0;
  localparam logic [1:0] PF_LATCH  = 2'd1;
endpackage

// File: rtl/prot_tick.sv
module prot_tick #(
  parameter int unsigned DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc_q, pc_d;

      always_comb begin
        pc_d = (pc_q == LAST) ? '0 : pc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end

      assign tick = (pc_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/prot_qual.sv
module prot_qual #(
  parameter int unsigned DELAY  = 1,
  parameter int          HYS    = 0,
  parameter bit          ABOVE  = 1'b1,
  parameter bit          STICKY = 1'b0,
  parameter int          W      = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic signed [W-1:0] value,
  input  logic signed [W-1:0] thr,
  output logic                fault_q,
  output logic                set_pulse
);
  localparam int CW = $clog2(DELAY + 2);
  localparam logic signed [W-1:0] HYS_V = W'(HYS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_d;
  logic          hit, clr, expire;
  logic signed [W-1:0] hi_lim, lo_lim;

  assign hi_lim = thr + HYS_V;
  assign lo_lim = thr - HYS_V;
  assign hit    = ABOVE ? (value >= thr) : (value <= thr);
  assign clr    = !STICKY && (ABOVE ? (value < lo_lim) : (value > hi_lim));
  assign expire = (32'(cnt_q) + 32'd1) >= DELAY;

  always_comb begin
    cnt_d     = cnt_q;
    fault_d   = fault_q;
    set_pulse = 1'b0;
    if (tick) begin
      if (fault_q) begin
        cnt_d = '0;
        if (clr) fault_d = 1'b0;
      end else if (hit) begin
        if (expire) begin
          fault_d   = 1'b1;
          cnt_d     = '0;
          set_pulse = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  // R2: a fault appears only after a qualifying tick
  assert_trip_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(tick && hit));
  // R3: a dropped condition restarts persistence
  assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !fault_q) |=> (cnt_q == '0));
  // R4: recovery happens only past the hysteresis band
  assert_clear_needs_margin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(clr && tick));
  // R13: permanent classes never fall
  assert_sticky_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (STICKY && fault_q) |=> fault_q);
endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import prot_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter logic [NCLS-1:0][DW-1:0] THR_RST = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  input  logic [NCLS-1:0]           set_vec,
  input  logic [NCLS-1:0]           live_vec,
  output logic [NCLS-1:0][DW-1:0]   thr_q,
  output logic [DW-1:0]             rd_data
);
  logic [NCLS-1:0][DW-1:0] thr_d;
  logic [NCLS-1:0]         stat_q, stat_d, w1c;

  always_comb begin
    thr_d = thr_q;
    for (int i = 0; i < NCLS; i++) begin
      if (wr_en && wr_addr == AW'(i)) thr_d[i] = wr_data;
    end
    w1c    = (wr_en && wr_addr == AW'(ADDR_STAT)) ? wr_data[NCLS-1:0] : '0;
    stat_d = (stat_q & ~w1c) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= THR_RST;
      stat_q <= '0;
    end else begin
      thr_q  <= thr_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (rd_addr == AW'(i)) rd_data = thr_q[i];
    end
    if (rd_addr == AW'(ADDR_STAT)) rd_data = {{(DW-NCLS){1'b0}}, stat_q};
    if (rd_addr == AW'(ADDR_LIVE)) rd_data = {{(DW-NCLS){1'b0}}, live_vec};
  end

  // R9: a new trip is always recorded, even during a clearing write
  assert_log_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int unsigned TICK_DIV = 125,
  parameter int unsigned DLY_OV   = 500000,
  parameter int unsigned DLY_UV   = 20000,
  parameter int unsigned DLY_SCD  = 50,
  parameter int unsigned DLY_OCC  = 160000,
  parameter int unsigned DLY_TEMP = 1000000,
  parameter int unsigned DLY_SOV  = 1000000,
  parameter int THR_OV  = 4300,
  parameter int THR_UV  = 2500,
  parameter int THR_SCD = 8000,
  parameter int THR_OCC = 800,
  parameter int THR_OTC = 450,
  parameter int THR_OTD = 600,
  parameter int THR_UTC = 0,
  parameter int THR_UTD = -200,
  parameter int THR_SOV = 4500,
  parameter int HYS_CELL = 100,
  parameter int HYS_CURR = 100,
  parameter int HYS_TEMP = 50,
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        cell_hi,
  input  logic [DW-1:0]        cell_lo,
  input  logic signed [DW-1:0] shunt,
  input  logic signed [DW-1:0] temp,
  input  logic [1:0]           pf_mode,
  input  logic [1:0]           fet_mode,
  input  logic                 host_chg_off,
  input  logic                 host_dsg_off,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic                 chg_off,
  output logic                 dsg_off,
  output logic                 fuse_fire,
  output logic                 pf_flag
);
  localparam int VW = DW + 2;
  localparam int unsigned DLY_TAB [NCLS] = '{DLY_OV, DLY_UV, DLY_SCD, DLY_OCC,
    DLY_TEMP, DLY_TEMP, DLY_TEMP, DLY_TEMP, DLY_SOV};
  localparam int HYS_TAB [NCLS] = '{HYS_CELL, HYS_CELL, HYS_CURR, HYS_CURR,
    HYS_TEMP, HYS_TEMP, HYS_TEMP, HYS_TEMP, HYS_CELL};
  localparam logic [NCLS-1:0][DW-1:0] THR_RST = {DW'(THR_SOV), DW'(THR_UTD),
    DW'(THR_UTC), DW'(THR_OTD), DW'(THR_OTC), DW'(THR_OCC), DW'(THR_SCD),
    DW'(THR_UV), DW'(THR_OV)};

  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  logic tick;
  prot_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_s), .tick(tick));

  logic [NCLS-1:0][DW-1:0] thr_q;
  logic [NCLS-1:0]         flt, setv;
  logic signed [VW-1:0]    vals [NCLS];
  logic signed [VW-1:0]    sh_x, tp_x;

  assign sh_x = VW'(shunt);
  assign tp_x = VW'(temp);

  always_comb begin
    vals[C_OV]  = signed'({2'b00, cell_hi});
    vals[C_UV]  = signed'({2'b00, cell_lo});
    vals[C_SCD] = -sh_x;
    vals[C_OCC] = sh_x;
    vals[C_OTC] = tp_x;
    vals[C_OTD] = tp_x;
    vals[C_UTC] = tp_x;
    vals[C_UTD] = tp_x;
    vals[C_SOV] = signed'({2'b00, cell_hi});
  end

  generate
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
      logic signed [VW-1:0] thr_x;
      assign thr_x = VW'(signed'(thr_q[g]));
      prot_qual #(
        .DELAY(DLY_TAB[g]), .HYS(HYS_TAB[g]),
        .ABOVE(ABOVE_MASK[g]), .STICKY(STICKY_MASK[g]), .W(VW)
      ) u_q (
        .clk(clk), .rst_n(rst_s), .tick(tick),
        .value(vals[g]), .thr(thr_x),
        .fault_q(flt[g]), .set_pulse(setv[g])
      );
    end
  endgenerate

  prot_regs #(.DW(DW), .AW(AW), .THR_RST(THR_RST)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .set_vec(setv),
    .live_vec(flt), .thr_q(thr_q), .rd_data(rd_data)
  );

  logic prot_chg, prot_dsg, pf_block;

  always_comb begin
    prot_chg  = |(flt & CHG_SIDE);
    prot_dsg  = |(flt & DSG_SIDE);
    pf_flag   = flt[C_SOV];
    pf_block  = pf_flag && (pf_mode != PF_FLAG);
    fuse_fire = pf_flag && (pf_mode != PF_FLAG) && (pf_mode != PF_LATCH);
    case (fet_mode)
      FM_AUTO: begin
        chg_off = prot_chg | pf_block;
        dsg_off = prot_dsg | pf_block;
      end
      FM_SHARED: begin
        chg_off = prot_chg | pf_block | host_chg_off;
        dsg_off = prot_dsg | pf_block | host_dsg_off;
      end
      default: begin
        chg_off = host_chg_off | pf_block;
        dsg_off = host_dsg_off | pf_block;
      end
    endcase
  end

  // R12: the fuse never fires with a FET left on
  assert_fuse_opens_fets_R12: assert property (@(posedge clk) disable iff (!rst_s)
    fuse_fire |-> (chg_off && dsg_off));
  // R13: the permanent-fail flag only leaves through reset
  assert_pf_holds_R13: assert property (@(posedge clk) disable iff (!rst_s)
    pf_flag |=> pf_flag);
endmodule

// File: tb/prot_guard_test.sv
module prot_guard_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] cell_hi, cell_lo;
  logic signed [15:0] shunt, temp;
  logic [1:0]  pf_mode, fet_mode;
  logic        host_chg_off, host_dsg_off, wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        chg_off, dsg_off, fuse_fire, pf_flag;

  prot_guard #(
    .TICK_DIV(1), .DLY_OV(12), .DLY_UV(5), .DLY_SCD(2), .DLY_OCC(8),
    .DLY_TEMP(4), .DLY_SOV(6)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cell_hi(cell_hi), .cell_lo(cell_lo),
    .shunt(shunt), .temp(temp), .pf_mode(pf_mode), .fet_mode(fet_mode),
    .host_chg_off(host_chg_off), .host_dsg_off(host_dsg_off),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .chg_off(chg_off),
    .dsg_off(dsg_off), .fuse_fire(fuse_fire), .pf_flag(pf_flag)
  );

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [15:0] rd;
    bit          c, d, f, p;
  } exp_t;

  exp_t sbq[$];
  event sb_ev, sb_done;
  int   n_chk = 0;
  int   n_fail = 0;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sb_ev);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (e.is_rd) begin
          if (rd_data !== e.rd) begin
            n_fail++;
            $display("FAIL %s rd_data actual %0h expected %0h", e.tag, rd_data, e.rd);
          end
        end else if ({chg_off, dsg_off, fuse_fire, pf_flag} !== {e.c, e.d, e.f, e.p}) begin
          n_fail++;
          $display("FAIL %s chg/dsg/fuse/pf actual %b%b%b%b expected %b%b%b%b", e.tag,
                   chg_off, dsg_off, fuse_fire, pf_flag, e.c, e.d, e.f, e.p);
        end
      end
      ->sb_done;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_out(string tag, bit c, bit d, bit f, bit p);
    exp_t e;
    e.tag = tag; e.is_rd = 1'b0; e.rd = '0;
    e.c = c; e.d = d; e.f = f; e.p = p;
    sbq.push_back(e);
    ->sb_ev;
    @(sb_done);
  endtask

  task automatic exp_rd(string tag, logic [3:0] a, logic [15:0] v);
    exp_t e;
    rd_addr = a;
    #1;
    e.tag = tag; e.is_rd = 1'b1; e.rd = v;
    e.c = 0; e.d = 0; e.f = 0; e.p = 0;
    sbq.push_back(e);
    ->sb_ev;
    @(sb_done);
  endtask

  task automatic host_write(logic [3:0] a, logic [15:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cell_hi = 16'd3700; cell_lo = 16'd3700; shunt = '0; temp = 16'sd250;
    pf_mode = 2'd0; fet_mode = 2'd0; host_chg_off = 0; host_dsg_off = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    do_reset();

    exp_out("R1 reset outputs", 0, 0, 0, 0);
    exp_rd("R1 threshold 0", 4'd0, 16'd4300);
    exp_rd("R1 threshold 8", 4'd8, 16'd4500);

    // R2 overvoltage
    cell_hi = 16'd4300;
    step(11); exp_out("R2 one tick short", 0, 0, 0, 0);
    step(1);  exp_out("R2 trip charge only", 1, 0, 0, 0);
    // R4 hysteresis
    cell_hi = 16'd4250;
    step(3);  exp_out("R4 inside band holds", 1, 0, 0, 0);
    cell_hi = 16'd4199;
    step(1);  exp_out("R4 past band clears", 0, 0, 0, 0);
    // R3 restart
    cell_hi = 16'd4400; step(10);
    cell_hi = 16'd3700; step(1);
    cell_hi = 16'd4400;
    step(11); exp_out("R3 restarted count short", 0, 0, 0, 0);
    step(1);  exp_out("R3 full delay trips", 1, 0, 0, 0);
    cell_hi = 16'd3700; step(1);
    exp_out("R4 recover", 0, 0, 0, 0);
    // R9 sticky log
    exp_rd("R9 log holds OV", 4'd9, 16'h0001);
    host_write(4'd9, 16'h0001);
    exp_rd("R9 write one clears", 4'd9, 16'h0000);

    // R5 undervoltage
    cell_lo = 16'd2500;
    step(4); exp_out("R5 short", 0, 0, 0, 0);
    step(1); exp_out("R5 trip discharge only", 0, 1, 0, 0);
    exp_rd("R9 live vector UV", 4'd10, 16'h0002);
    cell_lo = 16'd3700; step(1);
    exp_out("R5 recover", 0, 0, 0, 0);

    // R6 short circuit
    shunt = -16'sd8000;
    step(1); exp_out("R6 short", 0, 0, 0, 0);
    step(1); exp_out("R6 trip", 0, 1, 0, 0);
    shunt = '0; step(1);
    // R7 overcurrent in charge
    shunt = 16'sd800;
    step(7); exp_out("R7 short", 0, 0, 0, 0);
    step(1); exp_out("R7 trip", 1, 0, 0, 0);
    shunt = '0; step(1);
    exp_out("R7 recover", 0, 0, 0, 0);

    // R8 temperatures
    temp = 16'sd450;
    step(3); exp_out("R8 hot charge short", 0, 0, 0, 0);
    step(1); exp_out("R8 hot charge", 1, 0, 0, 0);
    temp = 16'sd600;
    step(4); exp_out("R8 hot discharge", 1, 1, 0, 0);
    temp = 16'sd250; step(1);
    temp = -16'sd200;
    step(3); exp_out("R8 cold short", 0, 0, 0, 0);
    step(1); exp_out("R8 cold both", 1, 1, 0, 0);
    exp_rd("R9 log classes 1-7", 4'd9, 16'h00FE);
    temp = 16'sd250; step(1);
    exp_out("R8 recover", 0, 0, 0, 0);

    // R10 threshold write
    host_write(4'd0, 16'd4000);
    exp_rd("R10 readback", 4'd0, 16'd4000);
    cell_hi = 16'd4100;
    step(11); exp_out("R10 short", 0, 0, 0, 0);
    step(1);  exp_out("R10 new threshold trips", 1, 0, 0, 0);
    cell_hi = 16'd3700; step(1);

    // R11 FET control modes
    host_chg_off = 1'b1; #1;
    exp_out("R11 auto ignores host", 0, 0, 0, 0);
    fet_mode = 2'd1; #1;
    exp_out("R11 shared ORs host", 1, 0, 0, 0);
    fet_mode = 2'd2; host_chg_off = 0; host_dsg_off = 1'b1;
    cell_lo = 16'd2500;
    step(5); exp_out("R11 host mode host only", 0, 1, 0, 0);
    host_dsg_off = 1'b0; #1;
    exp_out("R11 fault not driving", 0, 0, 0, 0);
    exp_rd("R11 fault still live", 4'd10, 16'h0002);
    cell_lo = 16'd3700; fet_mode = 2'd0; step(1);

    // R12 permanent fail
    cell_hi = 16'd4500;
    step(5); exp_out("R12 short", 0, 0, 0, 0);
    step(1); exp_out("R12 flag only", 0, 0, 0, 1);
    cell_hi = 16'd3700; step(2);
    exp_out("R13 latch survives recovery", 0, 0, 0, 1);
    pf_mode = 2'd1; #1;
    exp_out("R12 latch FETs off", 1, 1, 0, 1);
    pf_mode = 2'd2; #1;
    exp_out("R12 fuse", 1, 1, 1, 1);
    pf_mode = 2'd3; fet_mode = 2'd2; #1;
    exp_out("R12 fuse mode 3 in host mode", 1, 1, 1, 1);
    exp_rd("R9 log all", 4'd9, 16'h01FF);

    do_reset();
    exp_out("R13 reset clears latch", 0, 0, 0, 0);
    exp_rd("R1 threshold restored", 4'd0, 16'd4300);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule